// File: doc/BRIEF.md
# Rotating Shift-Register Message Store

This block is the message memory of a partially parallel decoder for quasi-cyclic low-density parity-check codes. It has no addresses. The storage is a set of circular shift registers, one per parallel lane. Each lane holds a group of consecutive messages of one cyclic submatrix. With the default sizes there are 57 lanes of 9 entries, which covers a 511-wide submatrix. An entry is 2 bits wide for intrinsic and variable-to-check messages and 3 bits wide for check-to-variable messages.

Consecutive rows and columns of a cyclic submatrix are neighbours in the shift. So rotating every lane by one entry per processing step always brings the next pending message to a fixed read tap. That tap is the head entry of each lane, and it is visible on the read bus in the same cycle, with no latency. A freshly computed result replaces the message that leaves the tap. If the lane advances at the same time, the result is written at the tail, so it comes back to the tap after a full revolution. A parallel load path fills every lane with intrinsic values before decoding starts.

Top module: `rot_msg_store`

## Requirements
- R1: After a cycle with `rst` high, every entry of every lane is zero.
- R2: The read bus shows the head entry (entry 0) of lane i on bits [i*WIDTH +: WIDTH], combinationally, with no clock delay.
- R3: With `load_en` high, entry j of lane i takes bits [(i*DEPTH+j)*WIDTH +: WIDTH] of `load_data` at the next edge.
- R4: Load takes priority: when `load_en` is high, `adv_en` and `wr_en` have no effect.
- R5: With `adv_en` high and `wr_en` low, each lane rotates by one entry: entry j+1 moves to entry j, and the old head moves to the tail (entry DEPTH-1).
- R6: With `adv_en` and `wr_en` both high, the lane rotates as in R5, but the tail takes that lane's slice of `wr_data` instead of the old head.
- R7: With `wr_en` high and `adv_en` low, the head entry of each lane is replaced in place by its slice of `wr_data`, and the other entries hold.
- R8: With `load_en`, `adv_en` and `wr_en` all low, the contents hold.
- R9: DEPTH consecutive advances without writes return every lane to its original contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load of all entries |
| load_data | input | LANES*DEPTH*WIDTH | Initial values, lane-major then entry |
| adv_en | input | 1 | Rotate every lane by one entry |
| wr_en | input | 1 | Write result at the head position |
| wr_data | input | LANES*WIDTH | One result per lane |
| rd_data | output | LANES*WIDTH | Head entry of every lane |

## Verification
The assertions in each lane check the single-cycle transitions on every clock: the clear after reset, the parallel load, the one-entry rotation, a write at the tail during rotation, a write in place at the head, and hold when idle. Two behaviours only show up over whole sequences, and the bench's scenarios cover them: a written value coming back to the tap after a full revolution, and a lane being restored after DEPTH plain advances. The bench also covers load winning over simultaneous advance and write. It compares the read bus with a behavioural model every cycle.

// File: rtl/rms_pkg.sv
package rms_pkg;

    typedef enum logic [2:0] {
        MODE_HOLD,
        MODE_LOAD,
        MODE_ROT,
        MODE_ROT_WR,
        MODE_PUT
    } mode_e;

    function automatic mode_e pick_mode(input logic ld, input logic adv, input logic wr);
        if (ld)
            return MODE_LOAD;
        else if (adv)
            return wr ? MODE_ROT_WR : MODE_ROT;
        else if (wr)
            return MODE_PUT;
        return MODE_HOLD;
    endfunction

endpackage

// File: rtl/rms_mode_dec.sv
module rms_mode_dec
    import rms_pkg::*;
(
    input  logic  load_en,
    input  logic  adv_en,
    input  logic  wr_en,
    output mode_e mode
);

    always_comb begin
        mode = pick_mode(load_en, adv_en, wr_en);
    end

endmodule

// File: rtl/rms_lane.sv
module rms_lane
    import rms_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int WIDTH = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  mode_e                  mode,
    input  logic [DEPTH*WIDTH-1:0] load_vec,
    input  logic [WIDTH-1:0]       wr_val,
    output logic [WIDTH-1:0]       head
);

    localparam int BITS = DEPTH * WIDTH;

    logic [WIDTH-1:0] ent [DEPTH];
    logic [BITS-1:0]  flat;

    for (genvar j = 0; j < DEPTH; j++) begin : g_flat
        assign flat[j*WIDTH +: WIDTH] = ent[j];
    end

    assign head = ent[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) ent[j] <= '0;
        end else begin
            case (mode)
                MODE_LOAD: begin
                    for (int j = 0; j < DEPTH; j++) ent[j] <= load_vec[j*WIDTH +: WIDTH];
                end
                MODE_ROT, MODE_ROT_WR: begin
                    for (int j = 0; j < DEPTH - 1; j++) ent[j] <= ent[j+1];
                    ent[DEPTH-1] <= (mode == MODE_ROT_WR) ? wr_val : ent[0];
                end
                MODE_PUT: ent[0] <= wr_val;
                default: ;
            endcase
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> flat == '0);

    assert_load_fill_R3: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_LOAD |=> flat == $past(load_vec));

    assert_put_head_R7: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_PUT |=> head == $past(wr_val));

    assert_rot_tail_R6: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_ROT_WR |=> flat[BITS-1 -: WIDTH] == $past(wr_val));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_HOLD |=> $stable(flat));

    if (DEPTH > 1) begin : g_rot_chk
        assert_rot_step_R5: assert property (@(posedge clk) disable iff (rst)
            mode == MODE_ROT |=> flat == {$past(flat[WIDTH-1:0]), $past(flat[BITS-1:WIDTH])});
    end else begin : g_rot_one
        assert_rot_step_R5: assert property (@(posedge clk) disable iff (rst)
            mode == MODE_ROT |=> $stable(flat));
    end

endmodule

// File: rtl/rot_msg_store.sv
module rot_msg_store
    import rms_pkg::*;
#(
    parameter int LANES = 57,
    parameter int DEPTH = 9,
    parameter int WIDTH = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_en,
    input  logic [LANES*DEPTH*WIDTH-1:0] load_data,
    input  logic                         adv_en,
    input  logic                         wr_en,
    input  logic [LANES*WIDTH-1:0]       wr_data,
    output logic [LANES*WIDTH-1:0]       rd_data
);

    localparam int LANE_BITS = DEPTH * WIDTH;

    mode_e mode;

    rms_mode_dec u_dec (
        .load_en (load_en),
        .adv_en  (adv_en),
        .wr_en   (wr_en),
        .mode    (mode)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rms_lane #(
            .DEPTH (DEPTH),
            .WIDTH (WIDTH)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode),
            .load_vec (load_data[i*LANE_BITS +: LANE_BITS]),
            .wr_val   (wr_data[i*WIDTH +: WIDTH]),
            .head     (rd_data[i*WIDTH +: WIDTH])
        );
    end

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (rst)
        load_en |=> rd_data[WIDTH-1:0] == $past(load_data[WIDTH-1:0]));

endmodule

// File: tb/test_rot_msg_store.sv
module test_rot_msg_store;

    localparam int LANES = 7;
    localparam int DEPTH = 5;
    localparam int WIDTH = 3;
    localparam int LB    = LANES * DEPTH * WIDTH;
    localparam int WB    = LANES * WIDTH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic          adv_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [LB-1:0] load_data = '0;
    logic [WB-1:0] wr_data = '0;
    logic [WB-1:0] rd_data;

    int total = 0;
    int bad = 0;
    int m [LANES][DEPTH];
    int snap [LANES][DEPTH];

    always #10 clk = ~clk;

    rot_msg_store #(.LANES(LANES), .DEPTH(DEPTH), .WIDTH(WIDTH)) i_rot_msg_store (
        .clk (clk), .rst (rst), .load_en (load_en), .load_data (load_data),
        .adv_en (adv_en), .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data)
    );

    task automatic model_step();
        if (rst) begin
            for (int l = 0; l < LANES; l++) for (int j = 0; j < DEPTH; j++) m[l][j] = 0;
        end else if (load_en) begin
            for (int l = 0; l < LANES; l++) for (int j = 0; j < DEPTH; j++)
                m[l][j] = int'(load_data[(l*DEPTH+j)*WIDTH +: WIDTH]);
        end else if (adv_en) begin
            for (int l = 0; l < LANES; l++) begin
                int t = wr_en ? int'(wr_data[l*WIDTH +: WIDTH]) : m[l][0];
                for (int j = 0; j < DEPTH - 1; j++) m[l][j] = m[l][j+1];
                m[l][DEPTH-1] = t;
            end
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) m[l][0] = int'(wr_data[l*WIDTH +: WIDTH]);
        end
    endtask

    task automatic compare(input string tag);
        int err = 0;
        total++;
        for (int l = 0; l < LANES; l++) begin
            if (int'(rd_data[l*WIDTH +: WIDTH]) != m[l][0] && err == 0) begin
                err = 1;
                $display("FAIL %s lane %0d: actual=%0d expected=%0d", tag, l,
                         rd_data[l*WIDTH +: WIDTH], m[l][0]);
            end
        end
        if (err != 0) bad++;
    endtask

    task automatic cyc(input logic r, input logic ld, input logic adv, input logic wr, input string tag);
        @(negedge clk);
        rst = r; load_en = ld; adv_en = adv; wr_en = wr;
        for (int k = 0; k < LB; k += 16) load_data[k +: 16] = 16'($urandom);
        for (int k = 0; k < WB; k += 16) wr_data[k +: 16] = 16'($urandom);
        @(posedge clk);
        #1;
        model_step();
        #4;
        compare(tag);
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(1, 0, 0, 0, "R1 reset");
        cyc(0, 1, 0, 0, "R3 load");
        cyc(1, 0, 0, 0, "R1 clear after load");
        cyc(0, 0, 0, 0, "R8 idle");
        cyc(0, 1, 0, 0, "R3 load");
        cyc(0, 0, 0, 0, "R8 idle");
        cyc(0, 0, 0, 0, "R8 idle");
        // R2: rd_data is checked against the model head in every cycle
        for (int l = 0; l < LANES; l++) for (int j = 0; j < DEPTH; j++) snap[l][j] = m[l][j];
        for (int k = 0; k < DEPTH; k++) cyc(0, 0, 1, 0, "R5 rotate");
        total++;
        begin
            int e = 0;
            for (int l = 0; l < LANES; l++) if (int'(rd_data[l*WIDTH +: WIDTH]) != snap[l][0]) e = 1;
            if (e != 0) begin
                bad++;
                $display("FAIL R9 restore: actual=%0d expected=%0d", rd_data[WIDTH-1:0], snap[0][0]);
            end
        end
        cyc(0, 0, 0, 1, "R7 put");
        for (int k = 0; k < DEPTH; k++) cyc(0, 0, 1, 0, "R7 others held");
        cyc(0, 0, 1, 1, "R6 rotate write");
        for (int k = 0; k < DEPTH; k++) cyc(0, 0, 1, 0, "R6 written value returns");
        cyc(0, 1, 1, 1, "R4 load over advance and write");
        cyc(0, 1, 0, 1, "R4 load over write");
        for (int k = 0; k < DEPTH; k++) cyc(0, 0, 1, 0, "R4 loaded contents");
        for (int k = 0; k < 200; k++)
            cyc(0, ($urandom % 10) == 0, $urandom % 2, $urandom % 2, "R2 mixed traffic");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule